// File: doc/BRIEF.md
# PHY Test-Port Register Writer

This block writes one 8-bit value into one 8-bit configuration register of a display PHY through the PHY's bit-level test port. The port has three parts: a test clock, a test clear line and an 8-bit bus. The PHY takes the register address from the bus on a falling edge of the test clock. It takes the register value from the bus on a rising edge. For that reason every access needs two separate clock pulses, one for the address and one for the value.

A controller issues a request that carries the address, the value and a phase divider. While the block is idle it accepts the request and raises `busy`. It then runs six phases of equal length, in this order:

1. address setup, clock low;
2. clock high;
3. clock low, address held after the falling edge;
4. value setup, clock low;
5. clock high, value held after the rising edge;
6. clock low.

At the end it pulses `done` for one cycle. The divider sets the length of each phase to `div_cfg + 1` system clock cycles, so the test clock can run as slowly as the PHY needs. The test clear line is kept deasserted outside reset.

Top module: `phy_tst_writer`

## Requirements
- R1: While `rst` is high, at every clock edge the block forces `busy=0`, `done=0`, `tst_clk=0`, `tst_bus=0` and `tst_clr=1`.
- R2: A request (`req_valid=1` at a clock edge) is accepted only while `busy=0`. A request made while busy has no effect on the bus, the pulse count or the number of `done` pulses.
- R3: The first test-clock pulse of an access carries the address. `tst_bus` equals `req_addr` from the first cycle of `busy` until one phase after the falling edge of that pulse, so the falling edge latches the address.
- R4: The second test-clock pulse carries the value. `tst_bus` equals `req_data` from one phase before the rising edge of that pulse until the end of the access.
- R5: Each access produces exactly two rising edges of `tst_clk`. `tst_clk` is 0 whenever `busy=0`.
- R6: Each phase lasts `div_cfg+1` cycles, where `div_cfg` is a 4-bit unsigned value by default. On every test-clock edge the bus has been stable for at least `div_cfg+1` cycles. Every change of the bus comes at least `div_cfg+1` cycles after the last test-clock edge. `busy` stays high for exactly `6*(div_cfg+1)` cycles.
- R7: `done` is high for exactly one cycle. It is high in the first cycle in which `busy` is low after an access, and `busy` falls only together with `done`.
- R8: From the second cycle after reset is released, `tst_clr` stays 0.
- R9: `div_cfg` is sampled when a request is accepted. Changing it during an access does not change that access's timing.
- R10: `tst_bus` is 0 whenever `busy=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request, taken only when idle |
| req_addr | input | BUS_W | PHY register address |
| req_data | input | BUS_W | Value to write |
| div_cfg | input | DIV_W | Phase length minus one, in clock cycles |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| tst_clk | output | 1 | Test clock to the PHY |
| tst_clr | output | 1 | Test clear to the PHY, active high |
| tst_bus | output | BUS_W | Test data bus to the PHY |

## Verification
The assertions take for granted that reset is applied from time zero and that `req_valid`, `req_addr`, `req_data` and `div_cfg` are settled at the active clock edge. They make no assumption about when a request arrives: requests that overlap a busy access are legal and must be ignored. The stimulus drives all inputs on the falling system-clock edge. It mixes back-to-back accesses, the smallest and largest divider values, a divider change in the middle of an access and a request made while busy. Timing is measured at the ports against a PHY model that latches the address on the falling edge and the value on the rising edge.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ASET = 3'd1,
    ST_AHI  = 3'd2,
    ST_ALO  = 3'd3,
    ST_DSET = 3'd4,
    ST_DHI  = 3'd5,
    ST_DLO  = 3'd6
  } ptw_state_e;

  localparam int PTW_PHASES = 6;
endpackage

// File: rtl/ptw_phase_timer.sv
module ptw_phase_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             expired
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ptw_seq_fsm.sv
module ptw_seq_fsm
  import ptw_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_data,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             expired,
  output ptw_state_e       state_nxt,
  output logic [BUS_W-1:0] bus_nxt,
  output logic             done_nxt,
  output logic             tmr_load,
  output logic [DIV_W-1:0] tmr_val
);
  ptw_state_e       state;
  logic [BUS_W-1:0] addr_q;
  logic [BUS_W-1:0] data_q;
  logic [DIV_W-1:0] div_q;
  logic             accept;

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    state_nxt = state;
    tmr_load  = 1'b0;
    tmr_val   = div_q;
    if (accept) begin
      state_nxt = ST_ASET;
      tmr_load  = 1'b1;
      tmr_val   = div_cfg;
    end else if (state != ST_IDLE && expired) begin
      tmr_load = 1'b1;
      case (state)
        ST_ASET: state_nxt = ST_AHI;
        ST_AHI:  state_nxt = ST_ALO;
        ST_ALO:  state_nxt = ST_DSET;
        ST_DSET: state_nxt = ST_DHI;
        ST_DHI:  state_nxt = ST_DLO;
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_nxt)
      ST_ASET, ST_AHI, ST_ALO: bus_nxt = accept ? req_addr : addr_q;
      ST_DSET, ST_DHI, ST_DLO: bus_nxt = data_q;
      default:                 bus_nxt = '0;
    endcase
  end

  assign done_nxt = (state == ST_DLO) && (state_nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      data_q <= '0;
      div_q  <= '0;
    end else begin
      state <= state_nxt;
      if (accept) begin
        addr_q <= req_addr;
        data_q <= req_data;
        div_q  <= div_cfg;
      end
    end
  end
endmodule

// File: rtl/ptw_port_drive.sv
module ptw_port_drive
  import ptw_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ptw_state_e       state_nxt,
  input  logic [BUS_W-1:0] bus_nxt,
  input  logic             done_nxt,
  output logic             busy,
  output logic             done,
  output logic             tst_clk,
  output logic             tst_clr,
  output logic [BUS_W-1:0] tst_bus
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      tst_clk <= 1'b0;
      tst_clr <= 1'b1;
      tst_bus <= '0;
    end else begin
      busy    <= (state_nxt != ST_IDLE);
      done    <= done_nxt;
      tst_clk <= (state_nxt == ST_AHI) || (state_nxt == ST_DHI);
      tst_clr <= 1'b0;
      tst_bus <= bus_nxt;
    end
  end
endmodule

// File: rtl/phy_tst_writer.sv
module phy_tst_writer
  import ptw_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [BUS_W-1:0] req_data,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             busy,
  output logic             done,
  output logic             tst_clk,
  output logic             tst_clr,
  output logic [BUS_W-1:0] tst_bus
);
  ptw_state_e       state_nxt;
  logic [BUS_W-1:0] bus_nxt;
  logic             done_nxt;
  logic             tmr_load;
  logic [DIV_W-1:0] tmr_val;
  logic             expired;

  ptw_seq_fsm #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .div_cfg   (div_cfg),
    .expired   (expired),
    .state_nxt (state_nxt),
    .bus_nxt   (bus_nxt),
    .done_nxt  (done_nxt),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val)
  );

  ptw_phase_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  ptw_port_drive #(.BUS_W(BUS_W)) u_drv (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .bus_nxt   (bus_nxt),
    .done_nxt  (done_nxt),
    .busy      (busy),
    .done      (done),
    .tst_clk   (tst_clk),
    .tst_clr   (tst_clr),
    .tst_bus   (tst_bus)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             tst_clk,
  input logic             tst_clr,
  input logic [BUS_W-1:0] tst_bus
);
  // R5
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tst_clk);

  // R6
  bus_stable_at_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (tst_clk != $past(tst_clk)) |-> (tst_bus == $past(tst_bus)));

  // R6
  bus_stable_while_high_chk: assert property (@(posedge clk) disable iff (rst)
    (tst_clk && $past(tst_clk)) |-> $stable(tst_bus));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R8
  clr_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !tst_clr);

  // R10
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tst_bus == '0));
endmodule

bind phy_tst_writer ptw_checker #(.BUS_W(BUS_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .tst_clk (tst_clk),
  .tst_clr (tst_clr),
  .tst_bus (tst_bus)
);

// File: tb/phy_tst_writer_tb.sv
module phy_tst_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 4;
  localparam int BUS_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [BUS_W-1:0] req_addr = '0;
  logic [BUS_W-1:0] req_data = '0;
  logic [DIV_W-1:0] div_cfg = '0;
  logic             busy, done, tst_clk, tst_clr;
  logic [BUS_W-1:0] tst_bus;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    int         dv;
  } item_t;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_tst_writer #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .div_cfg(div_cfg), .busy(busy), .done(done),
    .tst_clk(tst_clk), .tst_clr(tst_clr), .tst_bus(tst_bus)
  );

  // PHY model: address on falling edge of odd pulses, value on rising edge of even pulses
  logic [7:0] phy_mem [256];
  logic [7:0] phy_addr = '0;
  bit         want_addr = 1'b1;
  initial for (int i = 0; i < 256; i++) phy_mem[i] = '0;

  always @(posedge tst_clk) if (!want_addr) phy_mem[phy_addr] = tst_bus;
  always @(negedge tst_clk) begin
    if (want_addr) begin
      phy_addr  = tst_bus;
      want_addr = 1'b0;
    end else begin
      want_addr = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: timing measured at the ports, results popped from the scoreboard
  bit prev_clk = 1'b0, prev_rst = 1'b1, prev_done = 1'b0;
  logic [7:0] prev_bus = '0;
  int bus_held = 0, edge_age = 1000, busy_len = 0, pulses = 0, done_cnt = 0;

  always @(negedge clk) begin
    cycles++;
    if (!rst && !prev_rst) begin
      int p;
      p = (exp_q.size() != 0) ? exp_q[0].dv + 1 : 1;
      if (tst_clr) check(1'b0, "R8 tst_clr", tst_clr, 0);
      if (prev_done && done) check(1'b0, "R7 done width", 2, 1);
      if (tst_clk != prev_clk) begin
        if (bus_held < p) check(1'b0, "R6 setup before edge", bus_held, p);
        edge_age = 0;
        if (tst_clk) pulses++;
      end
      if (tst_bus != prev_bus) begin
        if (busy && edge_age < p) check(1'b0, "R6 hold after edge", edge_age, p);
        bus_held = 0;
      end
      bus_held++;
      edge_age++;
      if (busy) busy_len++;
      if (done) begin
        done_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(phy_mem[it.a] == it.d, "R3/R4 phy register", phy_mem[it.a], it.d);
          check(pulses == 2, "R5 pulse count", pulses, 2);
          check(busy_len == 6 * (it.dv + 1), "R6/R9 busy length", busy_len, 6 * (it.dv + 1));
          check(!busy && !tst_clk, "R7 done with idle", {busy, tst_clk}, 0);
          check(tst_bus == 0, "R10 idle bus", tst_bus, 0);
        end
        pulses = 0;
        busy_len = 0;
        edge_age = 1000;
      end
    end
    prev_clk  = tst_clk;
    prev_bus  = tst_bus;
    prev_rst  = rst;
    prev_done = done;
  end

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int dv);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_addr = a;
    req_data = d;
    div_cfg = dv[DIV_W-1:0];
    req_valid = 1'b1;
    it.a = a; it.d = d; it.dv = dv;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !tst_clk && tst_clr && tst_bus == 0, "R1 reset outputs",
          {busy, done, tst_clk, tst_clr}, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!tst_clr, "R8 clear released", tst_clr, 0);
    check(tst_bus == 0 && !tst_clk, "R10 idle after reset", tst_bus, 0);

    do_write(8'h12, 8'hA5, 0);     // smallest divider
    do_write(8'h40, 8'h3C, 2);     // back to back
    do_write(8'hFF, 8'h00, 15);    // largest divider
    do_write(8'h00, 8'hFF, 1);
    do_write(8'h77, 8'h77, 0);     // address equals value
    wait_idle();

    // R9: divider changes in the middle of an access
    do_write(8'h21, 8'h5E, 3);
    repeat (2) @(negedge clk);
    div_cfg = 4'd9;
    wait_idle();

    // R2: request while busy is ignored
    do_write(8'h30, 8'hC3, 2);
    repeat (3) @(negedge clk);
    req_addr = 8'h5A; req_data = 8'hEE; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    check(phy_mem[8'h5A] == 8'h00, "R2 ignored request", phy_mem[8'h5A], 0);
    check(done_cnt == 7, "R2 done count", done_cnt, 7);
    check(phy_mem[8'h12] == 8'hA5 && phy_mem[8'hFF] == 8'h00, "R3 earlier registers kept",
          phy_mem[8'h12], 8'hA5);
    check(!busy && !tst_clk && tst_bus == 0, "R5 idle end", {busy, tst_clk}, 0);
    finish_run();
  end

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    finish_run();
  end
endmodule